// File: doc/BRIEF.md
# JTAG Master Scan Sequencer

This block is a JTAG master. It drives the test clock, mode select and data-in lines toward a target chain and samples the data-out line. A host issues one command at a time. Each command has a 3-bit code, a data word, a bit count and three transfer flags. The block keeps its own copy of the target's TAP controller state. It uses that copy to reject moves that make no sense from the present state, and to find its way back to Run-Test/Idle from any scan state without going through Test-Logic-Reset.

The test clock is made from the system clock by a counter. Each half period lasts `HALF_DIV` system cycles, and the clock runs only while a command needs it. A transfer carries 1 to 32 bits in either bit order. The flags decide how the scan ends:

- It can stay in Shift, so a long scan can be built from several transfers.
- It can stop in Update.
- By default it goes on to Run-Test/Idle.

The captured bits come back packed in the same bit order that was used to send. At completion the block raises a one-cycle done pulse and an error bit.

Top module: `jtm_master`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block sets the following. `tap_state` = 0 (Test-Logic-Reset), `busy` = 0, `done` = 0, `tck` = 0, `tms` = 0 and `tdi` = 0.
- R2: `tck` is low whenever no command is using the clock. Each high phase lasts exactly `HALF_DIV` system cycles.
- R3: Code 0 (reset) gives five TCK cycles with TMS = 1 and TDI = 0. It ends with `tap_state` = 0, and it is legal from any state.
- R4: Code 1 (to Capture-IR) is legal only from Run-Test/Idle (1), Update-DR (8) or Update-IR (15). It drives TMS 1, 1, 0 with TDI = 0 and ends in Capture-IR (10). From any other state it reports an error and gives no TCK cycle.
- R5: Code 2 (to Capture-DR) is legal from the same states as code 1. It drives TMS 1, 0 with TDI = 0 and ends in Capture-DR (3).
- R6: Code 3 (enter Shift) is legal only from Capture-DR or Capture-IR. It gives one TCK cycle with TMS = 0, which reaches Shift-DR (4) or Shift-IR (11). From any other state it reports an error.
- R7: Code 4 (transfer) is legal only in Shift-DR or Shift-IR, with a bit count from 1 to 32. Any other case reports an error with no TCK cycle. Codes 6 and 7 always report an error.
- R8: With `cmd_lsb` = 1, word bit 0 is sent first; otherwise bit count−1 is sent first. The TDO bit sampled while word bit k was being sent is returned in `rd_word` bit k. Bits at or above the bit count read 0.
- R9: Without `cmd_noend`, TMS is 1 on the final data bit. With `cmd_noend`, TMS stays 0 on every data bit, the transfer ends in Shift, and no further cycles follow.
- R10: Without `cmd_noend`, one more TCK cycle with TMS = 1 reaches Update. After it, one TCK cycle with TMS = 0 reaches Run-Test/Idle (1), unless `cmd_noretidle` is set. In that case the block stops in Update.
- R11: Code 5 (return to idle) steps from the tracked state. From Select-* it takes TMS = 0. From Capture, Shift, Exit1, Pause and Exit2 it takes TMS = 1. From Update-* or Test-Logic-Reset it takes TMS = 0. It stops on reaching Run-Test/Idle, and it never enters Test-Logic-Reset on the way.
- R12: `busy` is high from the cycle after a command is accepted until the cycle after `done`. `done` is a single-cycle pulse. `cmd_valid` is ignored while `busy` is high.
- R13: `tap_state` follows the standard TAP state graph on each rising TCK edge, using the TMS value present at that edge. The encoding is: 0 Test-Logic-Reset, 1 Run-Test/Idle, 2 Select-DR, 3 Capture-DR, 4 Shift-DR, 5 Exit1-DR, 6 Pause-DR, 7 Exit2-DR, 8 Update-DR, 9 Select-IR, 10 Capture-IR, 11 Shift-IR, 12 Exit1-IR, 13 Pause-IR, 14 Exit2-IR, 15 Update-IR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, taken only when not busy |
| cmd_code | input | 3 | Command code (0 reset, 1 to Capture-IR, 2 to Capture-DR, 3 enter Shift, 4 transfer, 5 return to idle) |
| cmd_word | input | WORD_W | Data to send on a transfer |
| cmd_len | input | LEN_W | Bit count of a transfer |
| cmd_lsb | input | 1 | 1: least significant bit first |
| cmd_noend | input | 1 | Keep the TAP in Shift after the transfer |
| cmd_noretidle | input | 1 | Stop in Update instead of going on to idle |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Valid with done: command was rejected |
| rd_word | output | WORD_W | Captured TDO bits of the last transfer |
| tap_state | output | 4 | Tracked TAP state (R13 encoding) |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data toward the target |
| tdo | input | 1 | Test data from the target |

## Verification
The assertions on end states assume that the target follows the same TAP graph as the tracker. They also assume nothing else drives the chain, so the tracked state is the true one. The bench's target model moves only on the `tck` and `tms` lines the block drives, and it changes `tdo` only on falling TCK edges. This keeps the sampled value stable for the whole high phase. The host stimulus presents commands between negative system-clock edges. It raises `cmd_valid` during a busy period only on purpose, to show that the command is ignored.

// File: rtl/jtm_pkg.sv
// Shared types for the JTAG master: TAP state encoding, command codes and
// the TAP next-state function. Assumes the standard 16-state TAP graph.
package jtm_pkg;

    typedef enum logic [3:0] {
        TAP_TLR    = 4'd0,
        TAP_RTI    = 4'd1,
        TAP_SEL_DR = 4'd2,
        TAP_CAP_DR = 4'd3,
        TAP_SH_DR  = 4'd4,
        TAP_EX1_DR = 4'd5,
        TAP_PAU_DR = 4'd6,
        TAP_EX2_DR = 4'd7,
        TAP_UPD_DR = 4'd8,
        TAP_SEL_IR = 4'd9,
        TAP_CAP_IR = 4'd10,
        TAP_SH_IR  = 4'd11,
        TAP_EX1_IR = 4'd12,
        TAP_PAU_IR = 4'd13,
        TAP_EX2_IR = 4'd14,
        TAP_UPD_IR = 4'd15
    } tap_st_e;

    localparam logic [2:0] OP_RESET    = 3'd0;
    localparam logic [2:0] OP_CAP_IR   = 3'd1;
    localparam logic [2:0] OP_CAP_DR   = 3'd2;
    localparam logic [2:0] OP_SHIFT_IN = 3'd3;
    localparam logic [2:0] OP_XFER     = 3'd4;
    localparam logic [2:0] OP_IDLE     = 3'd5;

    // Next TAP state given the current one and the TMS level at a rising TCK.
    function automatic tap_st_e tap_next(tap_st_e s, logic m);
        tap_st_e n;
        case (s)
            TAP_TLR:    n = m ? TAP_TLR    : TAP_RTI;
            TAP_RTI:    n = m ? TAP_SEL_DR : TAP_RTI;
            TAP_SEL_DR: n = m ? TAP_SEL_IR : TAP_CAP_DR;
            TAP_CAP_DR: n = m ? TAP_EX1_DR : TAP_SH_DR;
            TAP_SH_DR:  n = m ? TAP_EX1_DR : TAP_SH_DR;
            TAP_EX1_DR: n = m ? TAP_UPD_DR : TAP_PAU_DR;
            TAP_PAU_DR: n = m ? TAP_EX2_DR : TAP_PAU_DR;
            TAP_EX2_DR: n = m ? TAP_UPD_DR : TAP_SH_DR;
            TAP_UPD_DR: n = m ? TAP_SEL_DR : TAP_RTI;
            TAP_SEL_IR: n = m ? TAP_TLR    : TAP_CAP_IR;
            TAP_CAP_IR: n = m ? TAP_EX1_IR : TAP_SH_IR;
            TAP_SH_IR:  n = m ? TAP_EX1_IR : TAP_SH_IR;
            TAP_EX1_IR: n = m ? TAP_UPD_IR : TAP_PAU_IR;
            TAP_PAU_IR: n = m ? TAP_EX2_IR : TAP_PAU_IR;
            TAP_EX2_IR: n = m ? TAP_UPD_IR : TAP_SH_IR;
            default:    n = m ? TAP_SEL_DR : TAP_RTI;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/jtm_clk_div.sv
// Test-clock divider. While run is high it makes a TCK cycle that starts low
// and changes phase every HALF_DIV system cycles. It flags the system cycle
// in which TCK rises and the one in which it falls. While run is low, TCK
// parks low and the count restarts. Assumes HALF_DIV >= 1.
module jtm_clk_div #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tck,
    output logic rise_p,
    output logic fall_p
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          phase_q;

    // Half-period counter and TCK phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tck    = phase_q;
    assign rise_p = run && !phase_q && (cnt_q == LAST);
    assign fall_p = run &&  phase_q && (cnt_q == LAST);

    // R2
    tck_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tck);
    // R2
    tck_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_p |=> tck);

endmodule

// File: rtl/jtm_tap_track.sv
// TAP state tracker. It copies the target's TAP controller by applying the
// TMS level at every rising TCK edge. Assumes the target sees the same TCK
// and TMS and nothing else moves it.
module jtm_tap_track
    import jtm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    step,
    input  logic    tms,
    output tap_st_e st
);
    // Advance the tracked state on each TCK rise.
    always_ff @(posedge clk) begin
        if (!rst_n)    st <= TAP_TLR;
        else if (step) st <= tap_next(st, tms);
    end

    // R13
    track_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(st));

endmodule

// File: rtl/jtm_seq.sv
// Command sequencer. It accepts one host command at a time and checks it
// against the tracked TAP state. Each TCK cycle is planned in one system
// cycle (TMS and TDI set up) and then clocked by the divider. TDO is sampled
// as TCK falls. Assumes tap_st mirrors the target.
module jtm_seq
    import jtm_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_lsb,
    input  logic              cmd_noend,
    input  logic              cmd_noretidle,
    input  tap_st_e           tap_st,
    input  logic              fall_p,
    input  logic              tdo,
    output logic              run,
    output logic              tms,
    output logic              tdi,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [WORD_W-1:0] rd_word
);
    localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [LEN_W-1:0] MAXLEN = LEN_W'(WORD_W);

    typedef enum logic [1:0] {F_IDLE, F_PLAN, F_CLK, F_DONE} fsm_e;

    fsm_e              fsm_q;
    logic [2:0]        op_q;
    logic [WORD_W-1:0] word_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  step_q;
    logic              lsb_q, noend_q, noret_q, err_q;

    logic              legal;
    logic              finished;
    logic [LEN_W-1:0]  tot;
    logic [LEN_W-1:0]  bit_pos;
    logic              data_ph;
    logic              tms_pl, tdi_pl;
    logic              upd_or_idle;

    // Legality of an incoming command against the tracked state.
    always_comb begin
        upd_or_idle = (tap_st == TAP_RTI) || (tap_st == TAP_UPD_DR) ||
                      (tap_st == TAP_UPD_IR);
        case (cmd_code)
            OP_RESET:    legal = 1'b1;
            OP_CAP_IR:   legal = upd_or_idle;
            OP_CAP_DR:   legal = upd_or_idle;
            OP_SHIFT_IN: legal = (tap_st == TAP_CAP_DR) || (tap_st == TAP_CAP_IR);
            OP_XFER:     legal = ((tap_st == TAP_SH_DR) || (tap_st == TAP_SH_IR)) &&
                                 (cmd_len != '0) && (cmd_len <= MAXLEN);
            OP_IDLE:     legal = 1'b1;
            default:     legal = 1'b0;
        endcase
    end

    // Step count of the latched command and the data bit position.
    always_comb begin
        case (op_q)
            OP_RESET:  tot = LEN_W'(5);
            OP_CAP_IR: tot = LEN_W'(3);
            OP_CAP_DR: tot = LEN_W'(2);
            OP_XFER:   tot = len_q + (noend_q ? LEN_W'(0) :
                                      (noret_q ? LEN_W'(1) : LEN_W'(2)));
            default:   tot = LEN_W'(1);
        endcase
        data_ph  = (op_q == OP_XFER) && (step_q < len_q);
        bit_pos  = lsb_q ? step_q : (len_q - 1'b1 - step_q);
        finished = (op_q == OP_IDLE) ? (tap_st == TAP_RTI) : (step_q == tot);
    end

    // TMS and TDI for the next TCK cycle of the latched command.
    always_comb begin
        tdi_pl = 1'b0;
        case (op_q)
            OP_RESET:    tms_pl = 1'b1;
            OP_CAP_IR:   tms_pl = (step_q != LEN_W'(2));
            OP_CAP_DR:   tms_pl = (step_q == '0);
            OP_SHIFT_IN: tms_pl = 1'b0;
            OP_XFER: begin
                if (data_ph) begin
                    tdi_pl = word_q[bit_pos[IDX_W-1:0]];
                    tms_pl = (step_q == len_q - 1'b1) && !noend_q;
                end else begin
                    tms_pl = (step_q == len_q);
                end
            end
            default: begin
                case (tap_st)
                    TAP_SEL_DR, TAP_SEL_IR, TAP_UPD_DR, TAP_UPD_IR, TAP_TLR,
                    TAP_RTI: tms_pl = 1'b0;
                    default: tms_pl = 1'b1;
                endcase
            end
        endcase
    end

    // Command acceptance, per-cycle planning and TDO capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q   <= F_IDLE;
            op_q    <= OP_RESET;
            word_q  <= '0;
            len_q   <= '0;
            step_q  <= '0;
            lsb_q   <= 1'b0;
            noend_q <= 1'b0;
            noret_q <= 1'b0;
            err_q   <= 1'b0;
            tms     <= 1'b0;
            tdi     <= 1'b0;
            rd_word <= '0;
        end else begin
            case (fsm_q)
                F_IDLE: if (cmd_valid) begin
                    op_q    <= cmd_code;
                    word_q  <= cmd_word;
                    len_q   <= cmd_len;
                    lsb_q   <= cmd_lsb;
                    noend_q <= cmd_noend;
                    noret_q <= cmd_noend | cmd_noretidle;
                    step_q  <= '0;
                    err_q   <= !legal;
                    fsm_q   <= legal ? F_PLAN : F_DONE;
                    if (legal && cmd_code == OP_XFER) rd_word <= '0;
                end
                F_PLAN: begin
                    if (finished) begin
                        fsm_q <= F_DONE;
                    end else begin
                        tms   <= tms_pl;
                        tdi   <= tdi_pl;
                        fsm_q <= F_CLK;
                    end
                end
                F_CLK: if (fall_p) begin
                    if (data_ph) rd_word[bit_pos[IDX_W-1:0]] <= tdo;
                    step_q <= step_q + 1'b1;
                    fsm_q  <= F_PLAN;
                end
                default: fsm_q <= F_IDLE;
            endcase
        end
    end

    assign run  = (fsm_q == F_CLK);
    assign busy = (fsm_q != F_IDLE);
    assign done = (fsm_q == F_DONE);
    assign err  = done && err_q;

    // R12
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R7
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> !err_q);
    // R3
    reset_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_RESET) |-> tap_st == TAP_TLR);
    // R4
    capir_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err_q && op_q == OP_CAP_IR) |-> tap_st == TAP_CAP_IR);
    // R9
    noend_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err_q && op_q == OP_XFER && noend_q) |->
        (tap_st == TAP_SH_DR || tap_st == TAP_SH_IR));
    // R10
    noret_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err_q && op_q == OP_XFER && noret_q && !noend_q) |->
        (tap_st == TAP_UPD_DR || tap_st == TAP_UPD_IR));
    // R11
    to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_IDLE) |-> tap_st == TAP_RTI);

endmodule

// File: rtl/jtm_master.sv
// JTAG master top. It joins the command sequencer, the TAP state tracker and
// the test-clock divider. Assumes a single target chain driven only by this
// block, and commands applied synchronously to clk.
module jtm_master
    import jtm_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int HALF_DIV = 2,
    localparam int LEN_W   = $clog2(WORD_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_lsb,
    input  logic              cmd_noend,
    input  logic              cmd_noretidle,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [WORD_W-1:0] rd_word,
    output logic [3:0]        tap_state,
    output logic              tck,
    output logic              tms,
    output logic              tdi,
    input  logic              tdo
);
    logic    run, rise_p, fall_p;
    tap_st_e st;

    jtm_seq #(.WORD_W(WORD_W), .LEN_W(LEN_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_word(cmd_word), .cmd_len(cmd_len), .cmd_lsb(cmd_lsb),
        .cmd_noend(cmd_noend), .cmd_noretidle(cmd_noretidle), .tap_st(st),
        .fall_p(fall_p), .tdo(tdo), .run(run), .tms(tms), .tdi(tdi),
        .busy(busy), .done(done), .err(err), .rd_word(rd_word)
    );

    jtm_tap_track track_i (
        .clk(clk), .rst_n(rst_n), .step(rise_p), .tms(tms), .st(st)
    );

    jtm_clk_div #(.HALF_DIV(HALF_DIV)) div_i (
        .clk(clk), .rst_n(rst_n), .run(run), .tck(tck),
        .rise_p(rise_p), .fall_p(fall_p)
    );

    assign tap_state = st;

    // R2
    tck_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tck);
    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/jtm_master_tb_top.sv
// Bench: a behavioural target TAP and a queue-based reference of the TMS/TDI
// stream. The tracked state is compared on every system clock.
module jtm_master_tb_top;
    localparam int HALF = 2;
    localparam int WW   = 32;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n, cmd_valid, cmd_lsb, cmd_noend, cmd_noretidle;
    logic [2:0]    cmd_code;
    logic [WW-1:0] cmd_word;
    logic [5:0]    cmd_len;
    logic          busy, done, err, tck, tms, tdi;
    logic          tdo = 1'b0;
    logic [WW-1:0] rd_word;
    logic [3:0]    tap_state;

    jtm_master #(.WORD_W(WW), .HALF_DIV(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_word(cmd_word), .cmd_len(cmd_len), .cmd_lsb(cmd_lsb),
        .cmd_noend(cmd_noend), .cmd_noretidle(cmd_noretidle), .busy(busy),
        .done(done), .err(err), .rd_word(rd_word), .tap_state(tap_state),
        .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
    );

    int    errs = 0, checks = 0;
    bit    live = 1'b0, seen_rise = 1'b0, finished = 1'b0;
    bit    q_tms[$], q_tdi[$], outq[$];
    int    ts = 0;
    logic [3:0] ir_sr = 4'h0;
    logic [7:0] dr_sr = 8'h00;
    realtime t_rise = 0.0;
    string cur_req = "R1";

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int ref_next(int s, bit m);
        case (s)
            0:  return m ? 0 : 1;
            1:  return m ? 2 : 1;
            2:  return m ? 9 : 3;
            3, 4: return m ? 5 : 4;
            5:  return m ? 8 : 6;
            6:  return m ? 7 : 6;
            7:  return m ? 8 : 4;
            9:  return m ? 0 : 10;
            10, 11: return m ? 12 : 11;
            12: return m ? 15 : 13;
            13: return m ? 14 : 13;
            14: return m ? 15 : 11;
            default: return m ? 2 : 1;
        endcase
    endfunction

    // Target TAP: capture and shift on rising TCK, and check the stream.
    always @(posedge tck) if (live) begin
        if (q_tms.size() == 0) begin
            chk(1'b0, "R12", "unexpected TCK cycle", 1, 0);
        end else begin
            bit et, ed;
            et = q_tms.pop_front();
            ed = q_tdi.pop_front();
            chk(tms == et, cur_req, "TMS at rise", tms, et);
            chk(tdi == ed, cur_req, "TDI at rise", tdi, ed);
        end
        if (ts == 3) dr_sr <= 8'h35;
        else if (ts == 4) begin outq.push_back(dr_sr[0]); dr_sr <= {tdi, dr_sr[7:1]}; end
        if (ts == 10) ir_sr <= 4'b0001;
        else if (ts == 11) begin outq.push_back(ir_sr[0]); ir_sr <= {tdi, ir_sr[3:1]}; end
        ts <= ref_next(ts, tms);
        t_rise = $realtime;
        seen_rise = 1'b1;
    end

    // Target output changes on falling TCK; high phase width check.
    always @(negedge tck) if (live) begin
        tdo <= (ts == 4) ? dr_sr[0] : (ts == 11) ? ir_sr[0] : 1'b0;
        if (seen_rise) chk(($realtime - t_rise) == HALF * 20.0, "R2", "TCK high width",
                           longint'($realtime - t_rise), HALF * 20);
    end

    // R13: tracked state compared on every clock.
    always @(negedge clk) if (live)
        chk(tap_state == ts[3:0], "R13", "tap_state", tap_state, ts);

    task automatic push(bit m, bit d);
        q_tms.push_back(m);
        q_tdi.push_back(d);
    endtask

    task automatic push_xfer(logic [WW-1:0] w, int n, bit lsb, bit ne, bit nr);
        for (int i = 0; i < n; i++)
            push((i == n - 1) && !ne, lsb ? w[i] : w[n - 1 - i]);
        if (!ne) push(1'b1, 1'b0);
        if (!ne && !nr) push(1'b0, 1'b0);
    endtask

    task automatic push_idle();
        int s = ts;
        while (s != 1) begin
            bit m = !(s == 0 || s == 2 || s == 9 || s == 8 || s == 15);
            push(m, 1'b0);
            s = ref_next(s, m);
        end
    endtask

    task automatic issue(logic [2:0] c, logic [WW-1:0] w, int n, bit lsb, bit ne, bit nr);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = c; cmd_word = w; cmd_len = 6'(n);
        cmd_lsb = lsb; cmd_noend = ne; cmd_noretidle = nr;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic finish_cmd(bit exp_err);
        int n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        chk(done == 1'b1, cur_req, "done seen", done, 1);
        chk(err == exp_err, cur_req, "err", err, exp_err);
        chk(q_tms.size() == 0, cur_req, "TCK cycles left over", q_tms.size(), 0);
        @(negedge clk);
        chk(!done && !busy, "R12", "done one cycle, busy low after", {done, busy}, 0);
        q_tms.delete(); q_tdi.delete();
    endtask

    task automatic run_cmd(logic [2:0] c, logic [WW-1:0] w, int n, bit lsb, bit ne,
                           bit nr, bit exp_err);
        outq.delete();
        issue(c, w, n, lsb, ne, nr);
        finish_cmd(exp_err);
    endtask

    task automatic check_rd(int n, bit lsb, string req);
        logic [WW-1:0] e = '0;
        for (int k = 0; k < n; k++) e[k] = lsb ? outq[k] : outq[n - 1 - k];
        chk(rd_word == e, req, "rd_word order", rd_word, e);
    endtask

    task automatic to_cap_dr_shift();
        cur_req = "R5"; push(1, 0); push(0, 0); run_cmd(3'd2, '0, 0, 0, 0, 0, 0);
        chk(tap_state == 4'd3, "R5", "state after capture-DR", tap_state, 3);
        cur_req = "R6"; push(0, 0); run_cmd(3'd3, '0, 0, 0, 0, 0, 0);
        chk(tap_state == 4'd4, "R6", "state after enter shift", tap_state, 4);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_code = '0; cmd_word = '0; cmd_len = '0;
        cmd_lsb = 1'b0; cmd_noend = 1'b0; cmd_noretidle = 1'b0;
        repeat (3) @(negedge clk);
        chk(tap_state == 0 && !busy && !done && !tck && !tms && !tdi, "R1",
            "reset state", {tap_state, busy, done, tck, tms, tdi}, 0);
        rst_n = 1'b1;
        live = 1'b1;

        cur_req = "R11"; push_idle(); run_cmd(3'd5, '0, 0, 0, 0, 0, 0);
        chk(tap_state == 4'd1, "R11", "idle from reset", tap_state, 1);

        cur_req = "R7"; run_cmd(3'd4, 32'hFF, 8, 1, 0, 0, 1);
        chk(tap_state == 4'd1, "R7", "transfer outside shift", tap_state, 1);

        // LSB-first default transfer
        to_cap_dr_shift();
        cur_req = "R8"; push_xfer(32'h5A, 8, 1, 0, 0);
        run_cmd(3'd4, 32'h5A, 8, 1, 0, 0, 0);
        chk(rd_word == 32'h35, "R8", "LSB readback", rd_word, 32'h35);
        check_rd(8, 1, "R8");
        chk(tap_state == 4'd1, "R10", "default end in idle", tap_state, 1);

        // MSB-first transfer
        to_cap_dr_shift();
        cur_req = "R8"; push_xfer(32'hC3, 8, 0, 0, 0);
        run_cmd(3'd4, 32'hC3, 8, 0, 0, 0, 0);
        chk(rd_word == 32'hAC, "R8", "MSB readback", rd_word, 32'hAC);
        check_rd(8, 0, "R8");

        // Full-width IR transfer
        cur_req = "R4"; push(1, 0); push(1, 0); push(0, 0);
        run_cmd(3'd1, '0, 0, 0, 0, 0, 0);
        chk(tap_state == 4'd10, "R4", "state after capture-IR", tap_state, 10);
        cur_req = "R6"; push(0, 0); run_cmd(3'd3, '0, 0, 0, 0, 0, 0);
        cur_req = "R8"; push_xfer(32'hDEADBEEF, 32, 1, 0, 0);
        run_cmd(3'd4, 32'hDEADBEEF, 32, 1, 0, 0, 0);
        chk(rd_word == 32'hEADBEEF1, "R8", "32-bit IR readback", rd_word, 32'hEADBEEF1);

        // Chained transfers with the open-end flag, then stop in Update
        to_cap_dr_shift();
        cur_req = "R9"; push_xfer(32'hF, 4, 1, 1, 0);
        run_cmd(3'd4, 32'hF, 4, 1, 1, 0, 0);
        chk(rd_word == 32'h5, "R9", "first open chunk", rd_word, 5);
        chk(tap_state == 4'd4, "R9", "stays in shift", tap_state, 4);
        push_xfer(32'h0, 4, 1, 1, 0);
        run_cmd(3'd4, 32'h0, 4, 1, 1, 0, 0);
        chk(rd_word == 32'h3, "R9", "second open chunk", rd_word, 3);
        cur_req = "R10"; push_xfer(32'h0, 3, 1, 0, 1);
        run_cmd(3'd4, 32'h0, 3, 1, 0, 1, 0);
        chk(rd_word == 32'h7, "R10", "bits shifted in earlier", rd_word, 7);
        chk(tap_state == 4'd8, "R10", "stops in update", tap_state, 8);

        // Capture-DR from Update, then back to idle from Capture
        cur_req = "R5"; push(1, 0); push(0, 0); run_cmd(3'd2, '0, 0, 0, 0, 0, 0);
        chk(tap_state == 4'd3, "R5", "capture-DR from update", tap_state, 3);
        cur_req = "R11"; push_idle(); run_cmd(3'd5, '0, 0, 0, 0, 0, 0);
        chk(tap_state == 4'd1, "R11", "idle from capture", tap_state, 1);

        // Illegal requests in Shift-DR
        to_cap_dr_shift();
        cur_req = "R4"; run_cmd(3'd1, '0, 0, 0, 0, 0, 1);
        chk(tap_state == 4'd4, "R4", "capture-IR refused", tap_state, 4);
        cur_req = "R6"; run_cmd(3'd3, '0, 0, 0, 0, 0, 1);
        cur_req = "R7"; run_cmd(3'd4, 32'h1, 0, 1, 0, 0, 1);
        run_cmd(3'd4, 32'h1, 33, 1, 0, 0, 1);
        run_cmd(3'd7, 32'h1, 4, 1, 0, 0, 1);
        chk(tap_state == 4'd4, "R7", "refused transfers leave shift", tap_state, 4);
        cur_req = "R11"; push_idle(); run_cmd(3'd5, '0, 0, 0, 0, 0, 0);
        chk(tap_state == 4'd1, "R11", "idle from shift", tap_state, 1);

        // Reset command, with a command offered while busy
        cur_req = "R3";
        for (int i = 0; i < 5; i++) push(1, 0);
        issue(3'd0, '0, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 3'd1;
        @(negedge clk);
        cmd_valid = 1'b0;
        finish_cmd(1'b0);
        chk(tap_state == 4'd0, "R3", "reset lands in TLR", tap_state, 0);
        repeat (40) @(negedge clk);
        chk(tap_state == 4'd0 && !busy, "R12", "busy-time command ignored",
            {tap_state, busy}, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule